// File: doc/BRIEF.md
# Linear Sensor Scan Sequencer

This block is the digital sequencer of a linear photodiode array with 128 pixels. It has a serial start input and a clock. A start pulse that is sampled on a rising edge does three things at once: it places a single select token in the first output slot, it cuts the sample/hold capacitors off from their integrators, and it opens a fixed integrator-reset window. On each later clock the token moves one slot. The output slots are, in order, two dummy slots, the 128 real pixels and two more dummy slots. One further clock empties the token register, and the output then returns to high impedance.

The analog path is not modelled. When a real pixel is selected, a pixel-number value stands in for the pixel's output voltage. The block also produces three flags:
- a protocol error, when the start input is still high on the second edge of a scan;
- an abort flag, when a fresh start pulse cuts a scan short;
- a sticky flag that reports once the first complete scan since reset has finished. Before that, scan data cannot be trusted.

Top module: `linescan_ctrl`

## Requirements
- R1: When `si` is high on a rising edge and the token is not in slot 1, the next state has the token in slot 1 (`pix_sel[0]`=1), `int_reset`=1 and `sh_connect`=0.
- R2: `pix_sel` is one-hot or zero. While a scan runs and no start pulse arrives, each clock moves the token from slot k (`pix_sel[k-1]`) to slot k+1.
- R3: Slots 1, 2, 131 and 132 are dummies, with `slot_real`=0 and `pix_data`=0. In slots 3 to 130, `slot_real`=1 and `pix_data` equals the slot number minus 2 (pixel 1 to 128).
- R4: A scan takes 133 clock edges. The 133rd edge (taken while the token is in slot 132) clears the token, and `out_en` stays low until the next start pulse.
- R5: `int_reset` stays high for exactly 18 cycles after the start edge. On the edge where it falls, `sh_connect` rises. `sh_connect` then stays high until the next start edge. After reset, `sh_connect` is 0 until the first window ends.
- R6: `out_en` is 1 exactly when the token is in one of slots 1 to 132.
- R7: A start pulse sampled on the 133rd edge begins a new scan directly in slot 1. It is not flagged as an abort.
- R8: `valid_scan` is 0 from reset until the first 133rd edge of a scan. From then on it stays 1 until the next reset.
- R9: `si` high on the edge while the token is in slot 1 pulses `proto_err` for one cycle. That edge does not restart the scan: the token moves on to slot 2.
- R10: `si` high on an edge while the token is in slots 2 to 131 pulses `scan_abort` for one cycle, puts the token back in slot 1 and restarts the reset window.
- R11: While `rst` is high, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| si | input | 1 | Serial start pulse |
| pix_sel | output | 132 | One-hot slot select from the token register |
| out_en | output | 1 | Output driver enable; 0 means high impedance |
| slot_real | output | 1 | Selected slot is a real pixel |
| pix_data | output | 8 | Stand-in pixel value (pixel number) |
| int_reset | output | 1 | Integrator reset window active |
| sh_connect | output | 1 | Sample capacitors connected, light integration running |
| proto_err | output | 1 | Start input held into the second edge |
| scan_abort | output | 1 | Scan cut short by a new start pulse |
| valid_scan | output | 1 | A complete scan has finished since reset |

## Verification
The bench sweeps every slot of whole scans and compares the select position, the dummy/real split, the pixel values and the reset window against slot arithmetic at every cycle. Two further patterns separate the protocol error from the abort: a start pulse held for two edges, and a start pulse re-issued in mid-scan and again in slot 131. A start pulse that lands exactly on the 133rd edge separates a normal back-to-back restart from an abort. A reset in mid-scan shows that the validity flag clears and comes back only after a full scan.

// File: rtl/linescan_pkg.sv
`timescale 1ns/1ps
package linescan_pkg;
  typedef enum logic [1:0] {
    SLOT_IDLE  = 2'd0,
    SLOT_DUMMY = 2'd1,
    SLOT_PIXEL = 2'd2
  } slot_kind_e;

  // pos: 0 = no token, 1..slots = output slot
  function automatic slot_kind_e classify(int unsigned pos, int unsigned lead,
                                          int unsigned npix, int unsigned slots);
    if (pos == 0 || pos > slots)                 return SLOT_IDLE;
    else if (pos > lead && pos <= lead + npix)   return SLOT_PIXEL;
    else                                         return SLOT_DUMMY;
  endfunction
endpackage

// File: rtl/linescan_token.sv
`timescale 1ns/1ps
module linescan_token #(
  parameter int SLOTS = 132
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic [SLOTS-1:0] sel
);
  logic [SLOTS-1:0] sel_q;

  generate
    for (genvar i = 0; i < SLOTS; i++) begin : g_stage
      if (i == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (rst) sel_q[i] <= 1'b0;
          else     sel_q[i] <= start;
        end
      end else begin : g_body
        always_ff @(posedge clk) begin
          if (rst)        sel_q[i] <= 1'b0;
          else if (start) sel_q[i] <= 1'b0;
          else            sel_q[i] <= sel_q[i-1];
        end
      end
    end
  endgenerate

  assign sel = sel_q;
endmodule

// File: rtl/linescan_seq.sv
`timescale 1ns/1ps
module linescan_seq
  import linescan_pkg::*;
#(
  parameter int LEAD   = 2,
  parameter int NPIX   = 128,
  parameter int TRAIL  = 2,
  parameter int DATA_W = 8,
  localparam int SLOTS = LEAD + NPIX + TRAIL,
  localparam int POS_W = $clog2(SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              si,
  output logic              start,
  output logic              out_en,
  output logic              slot_real,
  output logic [DATA_W-1:0] pix_data,
  output logic              proto_err,
  output logic              scan_abort,
  output logic              valid_scan
);
  logic [POS_W-1:0] pos_q, pos_d;
  logic             complete, perr_d, abort_d;
  slot_kind_e       kind_d;
  logic [DATA_W-1:0] data_d;

  always_comb begin
    complete = (pos_q == POS_W'(SLOTS));
    start    = si && (pos_q != POS_W'(1));
    perr_d   = si && (pos_q == POS_W'(1));
    abort_d  = si && (pos_q >= POS_W'(2)) && (pos_q < POS_W'(SLOTS));
    if (start)                        pos_d = POS_W'(1);
    else if (pos_q == '0 || complete) pos_d = '0;
    else                              pos_d = pos_q + POS_W'(1);
    kind_d = classify(int'(pos_d), LEAD, NPIX, SLOTS);
    data_d = (kind_d == SLOT_PIXEL) ? DATA_W'(pos_d - POS_W'(LEAD)) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q      <= '0;
      out_en     <= 1'b0;
      slot_real  <= 1'b0;
      pix_data   <= '0;
      proto_err  <= 1'b0;
      scan_abort <= 1'b0;
      valid_scan <= 1'b0;
    end else begin
      pos_q      <= pos_d;
      out_en     <= (kind_d != SLOT_IDLE);
      slot_real  <= (kind_d == SLOT_PIXEL);
      pix_data   <= data_d;
      proto_err  <= perr_d;
      scan_abort <= abort_d;
      if (complete) valid_scan <= 1'b1;
    end
  end
endmodule

// File: rtl/linescan_integ.sv
`timescale 1ns/1ps
module linescan_integ #(
  parameter int RESET_CLKS = 18,
  localparam int CNT_W = $clog2(RESET_CLKS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic int_reset,
  output logic sh_connect
);
  logic [CNT_W-1:0] left_q;
  logic             integ_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q  <= '0;
      integ_q <= 1'b0;
    end else if (start) begin
      left_q  <= CNT_W'(RESET_CLKS);
      integ_q <= 1'b0;
    end else if (left_q != '0) begin
      left_q  <= left_q - CNT_W'(1);
      if (left_q == CNT_W'(1)) integ_q <= 1'b1;
    end
  end

  assign int_reset  = (left_q != '0);
  assign sh_connect = integ_q;
endmodule

// File: rtl/linescan_ctrl.sv
`timescale 1ns/1ps
module linescan_ctrl #(
  parameter int LEAD       = 2,
  parameter int NPIX       = 128,
  parameter int TRAIL      = 2,
  parameter int RESET_CLKS = 18,
  parameter int DATA_W     = 8,
  localparam int SLOTS     = LEAD + NPIX + TRAIL
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              si,
  output logic [SLOTS-1:0]  pix_sel,
  output logic              out_en,
  output logic              slot_real,
  output logic [DATA_W-1:0] pix_data,
  output logic              int_reset,
  output logic              sh_connect,
  output logic              proto_err,
  output logic              scan_abort,
  output logic              valid_scan
);
  logic start;

  linescan_seq #(
    .LEAD(LEAD), .NPIX(NPIX), .TRAIL(TRAIL), .DATA_W(DATA_W)
  ) u_seq (
    .clk(clk), .rst(rst), .si(si), .start(start),
    .out_en(out_en), .slot_real(slot_real), .pix_data(pix_data),
    .proto_err(proto_err), .scan_abort(scan_abort), .valid_scan(valid_scan)
  );

  linescan_token #(.SLOTS(SLOTS)) u_token (
    .clk(clk), .rst(rst), .start(start), .sel(pix_sel)
  );

  linescan_integ #(.RESET_CLKS(RESET_CLKS)) u_integ (
    .clk(clk), .rst(rst), .start(start),
    .int_reset(int_reset), .sh_connect(sh_connect)
  );
endmodule

// File: rtl/linescan_ctrl_chk.sv
`timescale 1ns/1ps
module linescan_ctrl_chk #(
  parameter int SLOTS = 132
) (
  input logic             clk,
  input logic             rst,
  input logic             si,
  input logic [SLOTS-1:0] pix_sel,
  input logic             out_en,
  input logic             int_reset,
  input logic             sh_connect,
  input logic             proto_err,
  input logic             scan_abort,
  input logic             valid_scan
);
  p_start_r1: assert property (@(posedge clk) disable iff (rst)
    (si && !pix_sel[0]) |=> (pix_sel[0] && int_reset && !sh_connect));

  p_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pix_sel));

  p_shift_r2: assert property (@(posedge clk) disable iff (rst)
    (out_en && !si && !pix_sel[SLOTS-1]) |=> (pix_sel == ($past(pix_sel) << 1)));

  p_idle_r4: assert property (@(posedge clk) disable iff (rst)
    (pix_sel[SLOTS-1] && !si) |=> !out_en);

  p_handover_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(int_reset) |-> sh_connect);

  p_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !(int_reset && sh_connect));

  p_enable_r6: assert property (@(posedge clk) disable iff (rst)
    out_en == (pix_sel != '0));

  p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    valid_scan |=> valid_scan);

  p_noretrig_r9: assert property (@(posedge clk) disable iff (rst)
    proto_err |-> (pix_sel[1] && !scan_abort));

  p_restart_r10: assert property (@(posedge clk) disable iff (rst)
    scan_abort |-> (pix_sel[0] && int_reset));
endmodule

bind linescan_ctrl linescan_ctrl_chk #(.SLOTS(SLOTS)) u_chk (
  .clk(clk), .rst(rst), .si(si), .pix_sel(pix_sel), .out_en(out_en),
  .int_reset(int_reset), .sh_connect(sh_connect), .proto_err(proto_err),
  .scan_abort(scan_abort), .valid_scan(valid_scan)
);

// File: tb/linescan_ctrl_test.sv
`timescale 1ns/1ps
module linescan_ctrl_test;
  localparam int SLOTS = 132;

  logic clk = 1'b0, rst = 1'b1, si = 1'b0;
  logic [SLOTS-1:0] pix_sel;
  logic out_en, slot_real, int_reset, sh_connect, proto_err, scan_abort, valid_scan;
  logic [7:0] pix_data;

  linescan_ctrl uut (
    .clk(clk), .rst(rst), .si(si), .pix_sel(pix_sel), .out_en(out_en),
    .slot_real(slot_real), .pix_data(pix_data), .int_reset(int_reset),
    .sh_connect(sh_connect), .proto_err(proto_err), .scan_abort(scan_abort),
    .valid_scan(valid_scan)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int pos_m = 0, left_m = 0;
  bit integ_m = 0, valid_m = 0, perr_m = 0, abort_m = 0;

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sel_index();
    int idx = -1;
    for (int i = 0; i < SLOTS; i++)
      if (pix_sel[i]) idx = (idx == -1) ? i : -2;
    return idx;
  endfunction

  task automatic compare_all();
    int  exp_idx  = pos_m - 1;
    bit  exp_real = (pos_m >= 3) && (pos_m <= 130);
    int  exp_data = exp_real ? pos_m - 2 : 0;
    chk(sel_index() == exp_idx, "R2 token slot", sel_index(), exp_idx);
    chk(out_en == (pos_m != 0), "R6 out_en", out_en, pos_m != 0);
    chk(slot_real == exp_real, "R3 slot_real", slot_real, exp_real);
    chk(int'(pix_data) == exp_data, "R3 pix_data", pix_data, exp_data);
    chk(int_reset == (left_m != 0), "R5 int_reset", int_reset, left_m != 0);
    chk(sh_connect == integ_m, "R5 sh_connect", sh_connect, integ_m);
    chk(valid_scan == valid_m, "R8 valid_scan", valid_scan, valid_m);
    chk(proto_err == perr_m, "R9 proto_err", proto_err, perr_m);
    chk(scan_abort == abort_m, "R10 scan_abort", scan_abort, abort_m);
  endtask

  // one clock with start input s; expectations follow the requirements
  task automatic tick(bit s);
    bit start = s && (pos_m != 1);
    perr_m  = s && (pos_m == 1);
    abort_m = s && (pos_m >= 2) && (pos_m <= 131);
    if (pos_m == 132) valid_m = 1;
    if (start)                          pos_m = 1;
    else if (pos_m == 0 || pos_m == 132) pos_m = 0;
    else                                pos_m = pos_m + 1;
    if (start) begin
      left_m = 18; integ_m = 0;
    end else if (left_m != 0) begin
      if (left_m == 1) integ_m = 1;
      left_m = left_m - 1;
    end
    si = s;
    @(posedge clk);
    @(negedge clk);
    si = 1'b0;
    compare_all();
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) begin @(posedge clk); @(negedge clk); end
    pos_m = 0; left_m = 0; integ_m = 0; valid_m = 0; perr_m = 0; abort_m = 0;
    chk(pix_sel == '0 && !out_en && !slot_real && pix_data == 8'd0 && !int_reset &&
        !sh_connect && !proto_err && !scan_abort && !valid_scan,
        "R11 reset state", {out_en, int_reset, sh_connect, valid_scan}, 0);
    rst = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    repeat (2) tick(0);

    // first scan after reset
    tick(1);
    chk(pix_sel[0] && int_reset && !sh_connect, "R1 start edge", pix_sel[0], 1);
    repeat (17) tick(0);
    chk(int_reset, "R5 still in reset window", int_reset, 1);
    tick(0);
    chk(!int_reset && sh_connect, "R5 window ends after 18", int_reset, 0);
    repeat (113) tick(0);
    chk(pix_sel[SLOTS-1] && !valid_scan, "R8 invalid before 133rd edge", valid_scan, 0);
    tick(0);
    chk(!out_en && pix_sel == '0, "R4 high impedance after slot 132", out_en, 0);
    chk(valid_scan, "R8 valid after first scan", valid_scan, 1);
    repeat (5) tick(0);
    chk(!out_en && sh_connect, "R4 idle keeps integrating", out_en, 0);

    // start held into the second edge
    tick(1);
    tick(1);
    chk(proto_err && pix_sel[1], "R9 held start not retriggered", sel_index(), 1);
    repeat (131) tick(0);

    // aborts mid-scan and at slot 131, then restart on 133rd edge
    tick(1);
    repeat (49) tick(0);
    tick(1);
    chk(scan_abort && pix_sel[0], "R10 abort at slot 50", scan_abort, 1);
    repeat (130) tick(0);
    tick(1);
    chk(scan_abort, "R10 abort at slot 131", scan_abort, 1);
    repeat (131) tick(0);
    tick(1);
    chk(!scan_abort && pix_sel[0], "R7 back-to-back restart", scan_abort, 0);
    repeat (132) tick(0);

    // reset mid-scan clears validity
    tick(1);
    repeat (10) tick(0);
    do_reset();
    tick(1);
    repeat (132) tick(0);
    chk(valid_scan, "R8 valid after rescan", valid_scan, 1);
    repeat (3) tick(0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 20);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule